// File: doc/BRIEF.md
# Issue Queue Wakeup Scoreboard

This block keeps track of which physical registers have been produced and which instructions waiting in a small issue queue have all of their operands available. Each inserted instruction takes the lowest-numbered free slot. The slot records the instruction's class (integer, float or branch), its destination tag and up to two source tags, and it holds a ready bit for each source. When an execution result is broadcast on the completion port, every slot compares the tag against its unready sources in the same cycle, and the matching sources become ready. A slot whose sources are all ready appears in the ready vector for its class. An issue request then frees the slot.

The register scoreboard holds one bit for each physical register, counting the integer and float files together. The insert path reads it, so a source whose producer finished while the consumer was still on its way to the queue starts out ready. Without this read, such a consumer would wait for a broadcast that has already gone by. Three sticky error flags report inserts into a full queue, inserts with an illegal class, and a new producer created for a register that still has waiting consumers.

Top module: `iq_wakeup_sb`

## Requirements
- R1: After reset the free count equals ENTRIES, full is low, all three ready vectors and all three error flags are zero, and every scoreboard bit is clear. A source not flagged ready at insert waits until its tag completes.
- R2: An accepted insert occupies the lowest-numbered free slot, and the free count drops by one from the following cycle.
- R3: A completion whose tag is below NUM_INT_REGS+NUM_FP_REGS marks every matching unready source of every valid slot ready from the following cycle, and it sets that register's scoreboard bit.
- R4: A completion whose tag is at or above NUM_INT_REGS+NUM_FP_REGS changes no slot and no scoreboard bit.
- R5: At insert, a used source that is not flagged ready becomes ready at once if its scoreboard bit is set, or if its tag equals an in-range completion in the same cycle.
- R6: An accepted insert clears the scoreboard bit of its destination tag, so later consumers of that tag wait for a new completion.
- R7: Class codes are 0 integer, 1 float and 2 branch. Bit i of the ready vector for a class is set while slot i is valid, holds that class, and has both sources ready. A source whose use bit is 0 counts as ready.
- R8: An issue request naming a valid slot frees that slot from the following cycle. Its ready bit clears and the free count rises by one.
- R9: The full flag is high exactly when the free count is zero.
- R10: An insert while full is ignored, and it sets the sticky overflow flag.
- R11: An insert with class code 3 is ignored, and it sets the sticky illegal-class flag.
- R12: An accepted insert whose destination tag equals an unready source tag of a valid slot sets the sticky chain-error flag. This does not apply when that tag completes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | Insert request |
| ins_cls_i | input | 2 | Class code of the inserted instruction |
| ins_dst_i | input | TAG_W | Destination tag |
| ins_src_use_i | input | 2 | Source used, bit k for source k |
| ins_src_rdy_i | input | 2 | Source already known ready, bit k for source k |
| ins_src0_i | input | TAG_W | Tag of source 0 |
| ins_src1_i | input | TAG_W | Tag of source 1 |
| cmp_valid_i | input | 1 | Completion broadcast valid |
| cmp_tag_i | input | TAG_W | Completed destination tag |
| iss_valid_i | input | 1 | Issue request |
| iss_idx_i | input | IDX_W | Slot being issued |
| free_cnt_o | output | CNT_W | Number of free slots |
| full_o | output | 1 | No free slot |
| rdy_int_o | output | ENTRIES | Ready integer slots |
| rdy_fp_o | output | ENTRIES | Ready float slots |
| rdy_br_o | output | ENTRIES | Ready branch slots |
| ovf_o | output | 1 | Sticky insert-while-full flag |
| bad_cls_o | output | 1 | Sticky illegal-class flag |
| chain_err_o | output | 1 | Sticky producer-with-waiters flag |

## Verification
All state sits in registers, and every output is decoded from them, so any insert, completion or issue shows on the outputs exactly one rising edge after the edge that sampled it. The only exception is the insert-time bypass, which folds a same-cycle completion into the new slot's initial readiness and so lands on that same edge. The bench drives each stimulus just after a falling edge. It then lets one rising edge pass and compares outputs at the next falling edge, never at an edge. Stimuli that combine insert, completion and issue in one cycle are checked against the state expected after that single edge.

// File: rtl/iq_wsb_pkg.sv
package iq_wsb_pkg;
  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_FP  = 2'd1,
    CLS_BR  = 2'd2,
    CLS_BAD = 2'd3
  } iq_cls_e;
endpackage

// File: rtl/iq_wsb_scoreboard.sv
module iq_wsb_scoreboard #(
  parameter int NPR   = 32,
  parameter int TAG_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_vld_i,
  input  logic [TAG_W-1:0] set_tag_i,
  input  logic             clr_vld_i,
  input  logic [TAG_W-1:0] clr_tag_i,
  output logic [NPR-1:0]   bits_o
);
  for (genvar r = 0; r < NPR; r++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    bits_o[r] <= 1'b0;
      else if (clr_vld_i && clr_tag_i == TAG_W'(r))   bits_o[r] <= 1'b0; // new producer wins
      else if (set_vld_i && set_tag_i == TAG_W'(r))   bits_o[r] <= 1'b1;
    end
  end
endmodule

// File: rtl/iq_wsb_entry.sv
module iq_wsb_entry
  import iq_wsb_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  iq_cls_e               cls_i,
  input  logic [1:0][TAG_W-1:0] tag_i,
  input  logic [1:0]            rdy_i,
  input  logic                  wake_vld_i,
  input  logic [TAG_W-1:0]      wake_tag_i,
  input  logic                  free_i,
  output logic                  valid_o,
  output iq_cls_e               cls_o,
  output logic [1:0][TAG_W-1:0] tag_o,
  output logic [1:0]            rdy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      cls_o   <= CLS_INT;
      tag_o   <= '0;
      rdy_o   <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      cls_o   <= cls_i;
      tag_o   <= tag_i;
      rdy_o   <= rdy_i;
    end else begin
      if (free_i) valid_o <= 1'b0;
      for (int k = 0; k < 2; k++)
        if (valid_o && wake_vld_i && tag_o[k] == wake_tag_i) rdy_o[k] <= 1'b1;
    end
  end
endmodule

// File: rtl/iq_wsb_alloc.sv
module iq_wsb_alloc #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] busy_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!busy_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/iq_wakeup_sb.sv
module iq_wakeup_sb
  import iq_wsb_pkg::*;
#(
  parameter int NUM_INT_REGS = 16,
  parameter int NUM_FP_REGS  = 16,
  parameter int ENTRIES      = 8,
  parameter int TAG_W        = 6,
  localparam int NPR         = NUM_INT_REGS + NUM_FP_REGS,
  localparam int SB_W        = $clog2(NPR),
  localparam int IDX_W       = $clog2(ENTRIES),
  localparam int CNT_W       = $clog2(ENTRIES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ins_valid_i,
  input  logic [1:0]         ins_cls_i,
  input  logic [TAG_W-1:0]   ins_dst_i,
  input  logic [1:0]         ins_src_use_i,
  input  logic [1:0]         ins_src_rdy_i,
  input  logic [TAG_W-1:0]   ins_src0_i,
  input  logic [TAG_W-1:0]   ins_src1_i,
  input  logic               cmp_valid_i,
  input  logic [TAG_W-1:0]   cmp_tag_i,
  input  logic               iss_valid_i,
  input  logic [IDX_W-1:0]   iss_idx_i,
  output logic [CNT_W-1:0]   free_cnt_o,
  output logic               full_o,
  output logic [ENTRIES-1:0] rdy_int_o,
  output logic [ENTRIES-1:0] rdy_fp_o,
  output logic [ENTRIES-1:0] rdy_br_o,
  output logic               ovf_o,
  output logic               bad_cls_o,
  output logic               chain_err_o
);
  localparam logic [TAG_W:0] NPR_T = (TAG_W + 1)'(NPR);

  logic [NPR-1:0]              sb_bits;
  logic [ENTRIES-1:0]          ent_vld;
  iq_cls_e                     ent_cls [ENTRIES];
  logic [1:0][TAG_W-1:0]       ent_tag [ENTRIES];
  logic [1:0]                  ent_rdy [ENTRIES];
  logic                        slot_found;
  logic [IDX_W-1:0]            slot_idx;
  logic                        wake_ok, ins_acc, chain_hit;
  logic [1:0][TAG_W-1:0]       src_tag;
  logic [1:0]                  src_init;
  logic [CNT_W-1:0]            used_cnt;

  assign src_tag = {ins_src1_i, ins_src0_i};
  assign wake_ok = cmp_valid_i && ({1'b0, cmp_tag_i} < NPR_T);
  assign ins_acc = ins_valid_i && !full_o && (ins_cls_i != CLS_BAD);

  // readiness at insert: flagged, unused, scoreboard hit or same-cycle completion
  always_comb begin
    for (int k = 0; k < 2; k++) begin
      src_init[k] = !ins_src_use_i[k] || ins_src_rdy_i[k]
                  || (wake_ok && cmp_tag_i == src_tag[k]);
      if ({1'b0, src_tag[k]} < NPR_T && sb_bits[src_tag[k][SB_W-1:0]])
        src_init[k] = 1'b1;
    end
  end

  iq_wsb_scoreboard #(.NPR(NPR), .TAG_W(TAG_W)) u_sb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_vld_i (wake_ok),
    .set_tag_i (cmp_tag_i),
    .clr_vld_i (ins_acc),
    .clr_tag_i (ins_dst_i),
    .bits_o    (sb_bits)
  );

  iq_wsb_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .busy_i  (ent_vld),
    .found_o (slot_found),
    .idx_o   (slot_idx)
  );

  for (genvar j = 0; j < ENTRIES; j++) begin : g_ent
    logic all_rdy;
    iq_wsb_entry #(.TAG_W(TAG_W)) u_ent (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (ins_acc && slot_found && slot_idx == IDX_W'(j)),
      .cls_i      (iq_cls_e'(ins_cls_i)),
      .tag_i      (src_tag),
      .rdy_i      (src_init),
      .wake_vld_i (wake_ok),
      .wake_tag_i (cmp_tag_i),
      .free_i     (iss_valid_i && iss_idx_i == IDX_W'(j)),
      .valid_o    (ent_vld[j]),
      .cls_o      (ent_cls[j]),
      .tag_o      (ent_tag[j]),
      .rdy_o      (ent_rdy[j])
    );
    assign all_rdy      = ent_vld[j] && (&ent_rdy[j]);
    assign rdy_int_o[j] = all_rdy && ent_cls[j] == CLS_INT;
    assign rdy_fp_o[j]  = all_rdy && ent_cls[j] == CLS_FP;
    assign rdy_br_o[j]  = all_rdy && ent_cls[j] == CLS_BR;
  end

  always_comb begin
    used_cnt  = '0;
    chain_hit = 1'b0;
    for (int j = 0; j < ENTRIES; j++) begin
      used_cnt = used_cnt + CNT_W'(ent_vld[j]);
      for (int k = 0; k < 2; k++)
        if (ent_vld[j] && !ent_rdy[j][k] && ent_tag[j][k] == ins_dst_i)
          chain_hit = 1'b1;
    end
    if (wake_ok && cmp_tag_i == ins_dst_i) chain_hit = 1'b0;
  end

  assign free_cnt_o = CNT_W'(ENTRIES) - used_cnt;
  assign full_o     = (used_cnt == CNT_W'(ENTRIES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o       <= 1'b0;
      bad_cls_o   <= 1'b0;
      chain_err_o <= 1'b0;
    end else begin
      if (ins_valid_i && full_o)                      ovf_o       <= 1'b1;
      if (ins_valid_i && ins_cls_i == CLS_BAD)        bad_cls_o   <= 1'b1;
      if (ins_acc && chain_hit)                       chain_err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/iq_wakeup_sb_chk.sv
module iq_wakeup_sb_chk #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 6,
  parameter int NPR     = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ins_valid_i,
  input logic [1:0]         ins_cls_i,
  input logic               cmp_valid_i,
  input logic [TAG_W-1:0]   cmp_tag_i,
  input logic               iss_valid_i,
  input logic [IDX_W-1:0]   iss_idx_i,
  input logic [CNT_W-1:0]   free_cnt_o,
  input logic               full_o,
  input logic [ENTRIES-1:0] rdy_int_o,
  input logic [ENTRIES-1:0] rdy_fp_o,
  input logic [ENTRIES-1:0] rdy_br_o,
  input logic               ovf_o,
  input logic               bad_cls_o,
  input logic               chain_err_o
);
  // R2
  ins_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_i && !full_o && ins_cls_i != 2'd3 && !iss_valid_i
    |=> free_cnt_o == $past(free_cnt_o) - CNT_W'(1));
  // R4
  far_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i && {1'b0, cmp_tag_i} >= (TAG_W + 1)'(NPR) && !ins_valid_i && !iss_valid_i
    |=> $stable(rdy_int_o) && $stable(rdy_fp_o) && $stable(rdy_br_o));
  // R7
  cls_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdy_int_o & rdy_fp_o) | (rdy_int_o & rdy_br_o) | (rdy_fp_o & rdy_br_o)) == '0);
  // R10
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_i && full_o && !iss_valid_i |=> full_o && ovf_o);
  // R10
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  // R11
  bad_cls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_cls_o |=> bad_cls_o);
  // R12
  chain_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_err_o |=> chain_err_o);
  // R9
  full_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> free_cnt_o == '0 && !iss_valid_i |=> full_o || ins_valid_i == 1'b0);
endmodule

bind iq_wakeup_sb iq_wakeup_sb_chk #(
  .ENTRIES (ENTRIES),
  .TAG_W   (TAG_W),
  .NPR     (NUM_INT_REGS + NUM_FP_REGS)
) u_chk (.*);

// File: tb/test_iq_wakeup_sb.sv
module test_iq_wakeup_sb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ins_valid_i = 1'b0;
  logic [1:0] ins_cls_i = '0;
  logic [5:0] ins_dst_i = '0;
  logic [1:0] ins_src_use_i = '0;
  logic [1:0] ins_src_rdy_i = '0;
  logic [5:0] ins_src0_i = '0;
  logic [5:0] ins_src1_i = '0;
  logic       cmp_valid_i = 1'b0;
  logic [5:0] cmp_tag_i = '0;
  logic       iss_valid_i = 1'b0;
  logic [2:0] iss_idx_i = '0;
  logic [3:0] free_cnt_o;
  logic       full_o, ovf_o, bad_cls_o, chain_err_o;
  logic [7:0] rdy_int_o, rdy_fp_o, rdy_br_o;
  int total = 0, bad = 0;

  iq_wakeup_sb i_iq_wakeup_sb (.*);

  always #5 clk_i = ~clk_i;

  typedef struct packed {
    logic       ins;
    logic [1:0] cls;
    logic [5:0] dst;
    logic [1:0] use_s;
    logic [1:0] rdy_s;
    logic [5:0] s0;
    logic [5:0] s1;
    logic       cv;
    logic [5:0] ct;
    logic       iv;
    logic [2:0] ii;
    logic [7:0] e_int;
    logic [7:0] e_fp;
    logic [7:0] e_br;
    logic [3:0] e_free;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 6'd1, 2'b01, 2'b00, 6'd5,  6'd0, 1'b0, 6'd0,  1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 4'd7}, // R2 int waits on 5
    '{1'b1, 2'd1, 6'd2, 2'b11, 2'b00, 6'd1,  6'd5, 1'b0, 6'd0,  1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 4'd6}, // R2 fp waits on 1,5
    '{1'b0, 2'd0, 6'd0, 2'b00, 2'b00, 6'd0,  6'd0, 1'b1, 6'd5,  1'b0, 3'd0, 8'h01, 8'h00, 8'h00, 4'd6}, // R3 wake tag 5
    '{1'b1, 2'd2, 6'd3, 2'b01, 2'b00, 6'd5,  6'd0, 1'b0, 6'd0,  1'b0, 3'd0, 8'h01, 8'h00, 8'h04, 4'd5}, // R5 scoreboard hit
    '{1'b1, 2'd0, 6'd4, 2'b01, 2'b00, 6'd40, 6'd0, 1'b0, 6'd0,  1'b0, 3'd0, 8'h01, 8'h00, 8'h04, 4'd4}, // R2 waits on 40
    '{1'b0, 2'd0, 6'd0, 2'b00, 2'b00, 6'd0,  6'd0, 1'b1, 6'd40, 1'b0, 3'd0, 8'h01, 8'h00, 8'h04, 4'd4}, // R4 out of range
    '{1'b0, 2'd0, 6'd0, 2'b00, 2'b00, 6'd0,  6'd0, 1'b1, 6'd1,  1'b0, 3'd0, 8'h01, 8'h02, 8'h04, 4'd4}, // R7 fp ready
    '{1'b1, 2'd0, 6'd6, 2'b01, 2'b00, 6'd7,  6'd0, 1'b1, 6'd7,  1'b1, 3'd0, 8'h10, 8'h02, 8'h04, 4'd4}, // R8 issue + R5 bypass
    '{1'b1, 2'd0, 6'd5, 2'b00, 2'b00, 6'd0,  6'd0, 1'b0, 6'd0,  1'b0, 3'd0, 8'h11, 8'h02, 8'h04, 4'd3}, // R7 no sources
    '{1'b1, 2'd0, 6'd8, 2'b01, 2'b00, 6'd5,  6'd0, 1'b0, 6'd0,  1'b0, 3'd0, 8'h11, 8'h02, 8'h04, 4'd2}, // R6 dest cleared
    '{1'b0, 2'd0, 6'd0, 2'b00, 2'b00, 6'd0,  6'd0, 1'b1, 6'd5,  1'b0, 3'd0, 8'h31, 8'h02, 8'h04, 4'd2}  // R3 wake again
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ins_valid_i = 1'b0; cmp_valid_i = 1'b0; iss_valid_i = 1'b0;
  endtask

  task automatic ins(input logic [1:0] cls, input logic [5:0] dst,
                     input logic [1:0] use_s, input logic [5:0] s0);
    ins_valid_i = 1'b1; ins_cls_i = cls; ins_dst_i = dst;
    ins_src_use_i = use_s; ins_src_rdy_i = 2'b00; ins_src0_i = s0; ins_src1_i = '0;
    @(negedge clk_i);
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 free", free_cnt_o, 8);
    chk("R1 full", full_o, 0);
    chk("R1 ready", {rdy_int_o, rdy_fp_o, rdy_br_o}, 0);
    chk("R1 flags", {ovf_o, bad_cls_o, chain_err_o}, 0);

    for (int v = 0; v < NV; v++) begin
      ins_valid_i = VECS[v].ins; ins_cls_i = VECS[v].cls; ins_dst_i = VECS[v].dst;
      ins_src_use_i = VECS[v].use_s; ins_src_rdy_i = VECS[v].rdy_s;
      ins_src0_i = VECS[v].s0; ins_src1_i = VECS[v].s1;
      cmp_valid_i = VECS[v].cv; cmp_tag_i = VECS[v].ct;
      iss_valid_i = VECS[v].iv; iss_idx_i = VECS[v].ii;
      @(negedge clk_i);
      idle();
      chk("R7 int vector", rdy_int_o, VECS[v].e_int);
      chk("R7 fp vector", rdy_fp_o, VECS[v].e_fp);
      chk("R7 br vector", rdy_br_o, VECS[v].e_br);
      chk("R2 free count", free_cnt_o, VECS[v].e_free);
    end
    chk("R12 no false chain", {ovf_o, bad_cls_o, chain_err_o}, 0);

    // R9 fill the last two slots
    ins(2'd0, 6'd10, 2'b00, 6'd0);
    chk("R9 not yet full", full_o, 0);
    ins(2'd0, 6'd11, 2'b00, 6'd0);
    chk("R9 full", full_o, 1);
    chk("R9 free zero", free_cnt_o, 0);
    // R10 insert while full
    ins(2'd0, 6'd12, 2'b00, 6'd0);
    chk("R10 ovf", ovf_o, 1);
    chk("R10 unchanged", rdy_int_o, 8'hF1);
    // R8 issue slot 6
    iss_valid_i = 1'b1; iss_idx_i = 3'd6;
    @(negedge clk_i);
    idle();
    chk("R8 free", free_cnt_o, 1);
    chk("R8 ready cleared", rdy_int_o, 8'hB1);
    chk("R10 sticky", ovf_o, 1);
    // R11 illegal class
    ins(2'd3, 6'd13, 2'b00, 6'd0);
    chk("R11 flag", bad_cls_o, 1);
    chk("R11 ignored", free_cnt_o, 1);
    ins(2'd1, 6'd14, 2'b00, 6'd0);
    chk("R2 lowest free slot", rdy_fp_o, 8'h42);

    // R12 producer with waiters, after a fresh reset
    do_reset();
    chk("R1 flags after reset", {ovf_o, bad_cls_o, chain_err_o}, 0);
    ins(2'd0, 6'd1, 2'b01, 6'd9);
    chk("R1 scoreboard clear", rdy_int_o, 8'h00);
    ins(2'd0, 6'd9, 2'b00, 6'd0);
    chk("R12 chain error", chain_err_o, 1);
    chk("R12 insert kept", rdy_int_o, 8'h02);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule